// File: doc/BRIEF.md
# Host-Paced Single-Bit Serial Transmitter

This block sends serial data one bit at a time, with the controlling program supplying every bit. It has no shift register and no framing. A programmable rate generator divides the system clock into a square wave, the data-rate clock, with one period per transmitted bit. On each falling edge of that wave an interrupt latch asks the host for the next bit. The host selects the block and pulses a put strobe with the bit on data bus line 0. The bit waits in a staging flop until the next rising edge of the data-rate clock. On that edge it moves into a one-bit transmit buffer, which drives the serial line.

The host clears the interrupt after each bit. When a character is finished, the host drops the interrupt enable. The data-rate clock keeps running while the interrupt is disabled, the latch is held clear and the line rests at mark. The divisor register gives each half period as a count of system clocks. With a 50 MHz system clock and a 21-bit divisor, this covers rates from 20 to 9600 bits per second.

The rate generator is a two-state machine with phases PH_LOW and PH_HIGH. It moves PH_LOW→PH_HIGH (a rising edge) or PH_HIGH→PH_LOW (a falling edge) when the count reaches the divisor.

The interrupt controller has three states: IRQ_OFF, IRQ_ARMED and IRQ_PENDING.
- IRQ_OFF moves to IRQ_ARMED when the enable is high, or to IRQ_PENDING if a falling edge arrives in that same cycle.
- IRQ_ARMED moves to IRQ_PENDING on a falling edge.
- IRQ_PENDING moves to IRQ_ARMED on an accepted clear.
- Any state moves to IRQ_OFF when the enable is low.

Top module: `bpt_serial_tx`

## Requirements
- R1: While rst_n is low, rate_clk is 0, irq_req is 0 and txd is 1 (mark).
- R2: rate_clk toggles once every H system clocks, where H is the loaded divisor, and a divisor of 0 acts as 1. A div_we cycle loads div_val, restarts the count from zero and suppresses the toggle in that cycle. The reset divisor is 2604.
- R3: With irq_en high, irq_req is 1 from the first cycle in which rate_clk reads 0 after having read 1.
- R4: Once set, irq_req stays 1 until clr_irq is pulsed with sel high. A clr_irq pulse with sel low has no effect.
- R5: A clear that is accepted in the same cycle as a falling edge of rate_clk leaves irq_req at 1.
- R6: A put_stb pulse with sel high stages bus_bit0. txd takes the staged value in the cycle where rate_clk becomes 1.
- R7: A put_stb pulse with sel low leaves the staged bit unchanged.
- R8: While irq_en is low, irq_req is 0 and txd is 1 from the next cycle on. The staged bit is reset to 1 and rate_clk keeps toggling.
- R9: Without a new put, every later rising edge of rate_clk transmits the same staged bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Address select qualifying put and clear |
| put_stb | input | 1 | Put strobe, one cycle |
| bus_bit0 | input | 1 | Bit to transmit, data bus line 0 |
| clr_irq | input | 1 | Clear-interrupt strobe, one cycle |
| div_we | input | 1 | Divisor load strobe |
| div_val | input | DIV_W | Half-period divisor in system clocks |
| irq_en | input | 1 | Interrupt enable (level) |
| rate_clk | output | 1 | Data-rate clock square wave |
| irq_req | output | 1 | Interrupt request (latched) |
| txd | output | 1 | Serial transmit data |

## Verification
The embedded assertions check several rules on every cycle:
- the count stays within the divisor;
- each phase change comes from the terminal count;
- the latch is held while pending with no clear, and a falling edge always sets it;
- the disable forces the line to mark;
- the buffer stays stable between rising edges.

Only the bench scenarios show the measured toggle period for several divisors, including the 0 and 1 corner cases. They also show that a selected put reaches txd exactly at the rising edge, and that unselected strobes leave the outputs unchanged. A clear aligned with a falling edge, and the staged bit reverting to mark after a disable, are also covered only there.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } rate_phase_t;

    typedef enum logic [1:0] {
        IRQ_OFF     = 2'd0,
        IRQ_ARMED   = 2'd1,
        IRQ_PENDING = 2'd2
    } irq_state_t;
endpackage

// File: rtl/bpt_rate_gen.sv
module bpt_rate_gen
    import bpt_pkg::*;
#(
    parameter int DIV_W    = 21,
    parameter int DEF_HALF = 2604
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             rate_clk,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam logic [DIV_W-1:0] RESET_HALF = DIV_W'(DEF_HALF);
    localparam logic [DIV_W-1:0] ONE        = DIV_W'(1);

    rate_phase_t      phase_q, phase_d;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_m1;
    logic             tick;

    assign lim_m1 = (half_q == '0) ? '0 : (half_q - ONE);
    assign tick   = !div_we && (cnt_q >= lim_m1);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (tick) phase_d = PH_HIGH;
            PH_HIGH: if (tick) phase_d = PH_LOW;
            default: phase_d = PH_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            half_q  <= RESET_HALF;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (div_we) begin
                half_q <= div_val;
                cnt_q  <= '0;
            end else if (tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    always_comb begin
        rate_clk = (phase_q == PH_HIGH);
        rise_evt = tick && (phase_q == PH_LOW);
        fall_evt = tick && (phase_q == PH_HIGH);
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_m1);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_q) |-> ($past(cnt_q) == $past(lim_m1)) && !$past(div_we));
endmodule

// File: rtl/bpt_irq_fsm.sv
module bpt_irq_fsm
    import bpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic fall_evt,
    input  logic clr_acc,
    output logic irq_req
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_OFF: begin
                if (irq_en) state_d = fall_evt ? IRQ_PENDING : IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (!irq_en)       state_d = IRQ_OFF;
                else if (fall_evt) state_d = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (!irq_en)                   state_d = IRQ_OFF;
                else if (clr_acc && !fall_evt) state_d = IRQ_ARMED;
            end
            default: state_d = IRQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req = (state_q == IRQ_PENDING);
    end

    // R4
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_en && !clr_acc) |=> irq_req);

    // R3 R5
    fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && fall_evt) |=> irq_req);

    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_req);
endmodule

// File: rtl/bpt_tx_buf.sv
module bpt_tx_buf (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic put_acc,
    input  logic bit_in,
    input  logic rise_evt,
    output logic txd
);
    localparam logic MARK = 1'b1;

    logic stage_q;
    logic buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= MARK;
            buf_q   <= MARK;
        end else if (!irq_en) begin
            stage_q <= MARK;
            buf_q   <= MARK;
        end else begin
            if (put_acc)  stage_q <= bit_in;
            if (rise_evt) buf_q   <= stage_q;
        end
    end

    assign txd = buf_q;

    // R8
    mark_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> txd);

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !rise_evt) |=> $stable(txd));
endmodule

// File: rtl/bpt_serial_tx.sv
module bpt_serial_tx
    import bpt_pkg::*;
#(
    parameter int DIV_W    = 21,
    parameter int DEF_HALF = 2604
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             put_stb,
    input  logic             bus_bit0,
    input  logic             clr_irq,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             irq_en,
    output logic             rate_clk,
    output logic             irq_req,
    output logic             txd
);
    logic rise_evt;
    logic fall_evt;
    logic put_acc;
    logic clr_acc;

    assign put_acc = sel && put_stb;
    assign clr_acc = sel && clr_irq;

    bpt_rate_gen #(
        .DIV_W    (DIV_W),
        .DEF_HALF (DEF_HALF)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_we   (div_we),
        .div_val  (div_val),
        .rate_clk (rate_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    bpt_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_en   (irq_en),
        .fall_evt (fall_evt),
        .clr_acc  (clr_acc),
        .irq_req  (irq_req)
    );

    bpt_tx_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_en   (irq_en),
        .put_acc  (put_acc),
        .bit_in   (bus_bit0),
        .rise_evt (rise_evt),
        .txd      (txd)
    );

    // R6
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !rise_evt) |=> $stable(txd));
endmodule

// File: tb/sim_bpt_serial_tx.sv
module sim_bpt_serial_tx;
    localparam int DW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, put_stb = 1'b0, bus_bit0 = 1'b0, clr_irq = 1'b0;
    logic div_we = 1'b0, irq_en = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic rate_clk, irq_req, txd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_div = 2604, m_cnt = 0, m_lim = 1;
    bit m_rc = 0, m_irq = 0, m_stage = 1, m_buf = 1;
    bit m_tick, m_rise, m_fall;

    bpt_serial_tx #(.DIV_W(DW), .DEF_HALF(2604)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .put_stb(put_stb),
        .bus_bit0(bus_bit0), .clr_irq(clr_irq), .div_we(div_we),
        .div_val(div_val), .irq_en(irq_en), .rate_clk(rate_clk),
        .irq_req(irq_req), .txd(txd)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 2604; m_cnt = 0; m_rc = 0; m_irq = 0; m_stage = 1; m_buf = 1;
        end else begin
            m_lim  = (m_div == 0) ? 1 : m_div;
            m_tick = !div_we && (m_cnt >= m_lim - 1);
            m_rise = m_tick && !m_rc;
            m_fall = m_tick && m_rc;
            if (!irq_en) m_buf = 1; else if (m_rise) m_buf = m_stage;
            if (!irq_en) m_stage = 1; else if (sel && put_stb) m_stage = bus_bit0;
            if (!irq_en) m_irq = 0;
            else if (m_fall) m_irq = 1;
            else if (sel && clr_irq) m_irq = 0;
            if (div_we) begin m_div = int'(div_val); m_cnt = 0; end
            else if (m_tick) begin m_cnt = 0; m_rc = !m_rc; end
            else m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rate_clk == m_rc, "R2 rate_clk model", rate_clk, m_rc);
            check(irq_req == m_irq, "R3 irq_req model", irq_req, m_irq);
            check(txd == m_buf, "R6 txd model", txd, m_buf);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic load_div(input int v);
        div_we = 1'b1; div_val = DW'(v);
        step();
        div_we = 1'b0;
    endtask

    task automatic measure(input int exp, input string tag);
        int n = 0;
        logic prev;
        prev = rate_clk;
        while (rate_clk == prev) step();
        prev = rate_clk;
        while (rate_clk == prev) begin step(); n++; end
        check(n == exp, tag, n, exp);
    endtask

    task automatic wait_irq();
        while (!irq_req) step();
    endtask

    task automatic wait_rise();
        while (rate_clk) step();
        while (!rate_clk) step();
    endtask

    task automatic send_bit(input bit b);
        wait_irq();
        sel = 1'b1; put_stb = 1'b1; bus_bit0 = b; clr_irq = 1'b1;
        step();
        sel = 1'b0; put_stb = 1'b0; clr_irq = 1'b0;
        check(irq_req == 1'b0, "R4 selected clear", irq_req, 0);
        wait_rise();
        check(txd == b, "R6 bit on rising edge", txd, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(rate_clk == 1'b0, "R1 reset rate_clk", rate_clk, 0);
        check(irq_req == 1'b0, "R1 reset irq_req", irq_req, 0);
        check(txd == 1'b1, "R1 reset txd", txd, 1);
        rst_n = 1'b1;
        step();
        load_div(3);
        measure(3, "R2 period div 3");

        // R8: disabled, a selected put is discarded and irq stays low
        sel = 1'b1; put_stb = 1'b1; bus_bit0 = 1'b0;
        step();
        sel = 1'b0; put_stb = 1'b0;
        repeat (8) step();
        check(irq_req == 1'b0, "R8 irq low while disabled", irq_req, 0);
        check(txd == 1'b1, "R8 mark while disabled", txd, 1);
        irq_en = 1'b1;
        wait_rise();
        check(txd == 1'b1, "R8 staged bit reset to mark", txd, 1);

        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b0);

        // R9: no put, only clear; bit repeats
        wait_irq();
        sel = 1'b1; clr_irq = 1'b1; step(); sel = 1'b0; clr_irq = 1'b0;
        wait_rise();
        check(txd == 1'b0, "R9 repeated bit", txd, 0);

        // R7: unselected put ignored
        wait_irq();
        put_stb = 1'b1; bus_bit0 = 1'b1; step(); put_stb = 1'b0;
        // R4: unselected clear ignored
        clr_irq = 1'b1; step(); clr_irq = 1'b0;
        check(irq_req == 1'b1, "R4 unselected clear ignored", irq_req, 1);
        wait_rise();
        check(txd == 1'b0, "R7 unselected put ignored", txd, 0);

        // R5: selected clear coincident with falling edge
        while (!(m_rc && (m_cnt == m_div - 1))) step();
        sel = 1'b1; clr_irq = 1'b1; step(); sel = 1'b0; clr_irq = 1'b0;
        check(irq_req == 1'b1, "R5 set wins over clear", irq_req, 1);
        sel = 1'b1; clr_irq = 1'b1; step(); sel = 1'b0; clr_irq = 1'b0;
        check(irq_req == 1'b0, "R4 later clear", irq_req, 0);

        send_bit(1'b1);

        // R8: disable ends character, clock keeps running
        irq_en = 1'b0;
        step();
        check(irq_req == 1'b0, "R8 irq cleared on disable", irq_req, 0);
        check(txd == 1'b1, "R8 mark after disable", txd, 1);
        measure(3, "R8 clock runs while disabled");

        load_div(0);
        measure(1, "R2 divisor 0 acts as 1");
        load_div(1);
        measure(1, "R2 divisor 1");
        load_div(5);
        measure(5, "R2 divisor 5");

        irq_en = 1'b1;
        send_bit(1'b0);
        send_bit(1'b1);
        irq_en = 1'b0;
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule